// File: doc/BRIEF.md
# H-Bridge Switch Sequencer with Per-Leg Fault Latch

This block sits between the digital command inputs of a full-bridge motor driver and the four gate drivers of its power switches. From two direction inputs, a PWM input and two per-leg enable inputs it works out which of the four switches may conduct. The switches are high-side A, high-side B, low-side A and low-side B. It modulates only the low-side switches with PWM. On every change of direction it holds all switches off for a programmable number of cycles.

Digital protection flags come in from the analog front end: a supply-low flag, a supply-high flag, one overtemperature flag per high-side switch and one overcurrent flag per low-side switch. A supply flag shuts the whole bridge down only while it is present. A switch flag latches its own leg off and asks for that leg's diagnostic pull-down. The latch is released only by a rising edge on that leg's direction input. The block also drives a current-sense enable and a standby indication.

Top module: `hbridge_ctrl`

## Requirements
- R1: With both legs enabled and PWM high, the direction pair {in_a,in_b} selects the switches as follows. 11 turns both high-sides on. 10 turns on high-side A and low-side B. 01 turns on high-side B and low-side A. 00 turns both low-sides on.
- R2: While the synchronized PWM input is low, both low-side outputs are off and the high-side outputs keep their state. When PWM returns high, the low-sides resume the selected state.
- R3: While a leg's enable input (en_a for leg A, en_b for leg B) is low, both switches of that leg are off. The other leg is not affected.
- R4: Leg A faults when ot_hs[0] or oc_ls[0] is high at a clock edge, and leg B faults when ot_hs[1] or oc_ls[1] is high. From the next cycle both switches of the faulted leg are off and its diagnostic pull-down (diag_pd_a or diag_pd_b) is high. The other leg keeps working.
- R5: A latched fault clears only on a rising edge of the synchronized direction input of the same leg, and only when the fault flags of that leg are low. A falling edge does not clear it, and an edge on the other leg's input does not clear it. The pull-down drops one cycle after the synchronized edge.
- R6: While uv_flag or ov_flag is high, all four switch outputs are off in the same cycle. When the flag drops, the outputs return with nothing latched.
- R7: When the decoded direction changes, all four switches are off for exactly DEAD_CYC+1 consecutive cycles before the switches of the new mode turn on.
- R8: The high-side and low-side outputs of one leg are never on in the same cycle. Neither is on in the cycle directly after the other was on.
- R9: sense_en is high only when the synchronized cs_dis is low and the active mode is 10 or 01. It is low in both brake modes.
- R10: standby is high exactly when the synchronized in_a, in_b, pwm_in, en_a and en_b are all low and no leg fault is latched.
- R11: During and right after reset, all switch and pull-down outputs are low, no fault is latched and standby is high.
- R12: Each command input (in_a, in_b, pwm_in, en_a, en_b, cs_dis) passes through SYNC_STAGES flops. A change takes effect on the outputs SYNC_STAGES clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Direction input, leg A |
| in_b | input | 1 | Direction input, leg B |
| pwm_in | input | 1 | PWM command gating the low-sides |
| en_a | input | 1 | Enable for leg A (low turns the leg off) |
| en_b | input | 1 | Enable for leg B (low turns the leg off) |
| cs_dis | input | 1 | High disables the current-sense output |
| uv_flag | input | 1 | Supply-low flag |
| ov_flag | input | 1 | Supply-high flag |
| ot_hs | input | 2 | High-side overtemperature flags, bit 0 leg A, bit 1 leg B |
| oc_ls | input | 2 | Low-side overcurrent flags, bit 0 leg A, bit 1 leg B |
| hs_a_on | output | 1 | Gate enable, high-side A |
| hs_b_on | output | 1 | Gate enable, high-side B |
| ls_a_on | output | 1 | Gate enable, low-side A |
| ls_b_on | output | 1 | Gate enable, low-side B |
| diag_pd_a | output | 1 | Diagnostic pull-down request, leg A |
| diag_pd_b | output | 1 | Diagnostic pull-down request, leg B |
| sense_en | output | 1 | Current-sense enable |
| standby | output | 1 | Standby indication |

## Verification
The bench builds the block with SYNC_STAGES=2 and DEAD_CYC=8. The non-overlap window is then short enough to be checked at both ends: the last cycle all switches are off and the first cycle the new switches are on. The synchronizer latency can likewise be checked by looking one cycle before and one cycle after the change. The default delay of 40000 cycles would leave far fewer direction changes and fault-clear sequences within the cycle budget. The small values allow every mode change, the fault clear with and without a held flag, and the standby procedure after a fault to be checked cycle by cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;
   // direction pair {in_a, in_b}; the encoding is decoded bitwise per leg
   typedef enum logic [1:0] {
      MODE_BRK_LO = 2'b00,
      MODE_CCW    = 2'b01,
      MODE_CW     = 2'b10,
      MODE_BRK_HI = 2'b11
   } hb_mode_e;

   localparam int NUM_LEGS = 2;

   // direction bit of a leg: 1 selects its high-side, 0 its low-side
   function automatic logic leg_dir(input hb_mode_e m, input int leg);
      return (leg == 0) ? m[1] : m[0];
   endfunction

   function automatic logic mode_drives(input hb_mode_e m);
      return m[1] ^ m[0];
   endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hb_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hb_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_leg_fault.sv
module hb_leg_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_s,
   input  logic fault_in,
   output logic flt_q
);
   logic dir_prev;
   logic dir_rise;

   assign dir_rise = dir_s & ~dir_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_prev <= 1'b0;
         flt_q    <= 1'b0;
      end else begin
         dir_prev <= dir_s;
         if (fault_in) begin
            flt_q <= 1'b1;
         end else if (dir_rise) begin
            flt_q <= 1'b0;
         end
      end
   end

   // R4
   fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_q) |-> $past(fault_in));

   // R5
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flt_q) |-> ($past(dir_s) && !$past(dir_s, 2) && !$past(fault_in)));
endmodule

// File: rtl/hb_dead.sv
module hb_dead
   import hb_pkg::*;
#(
   parameter int DEAD_CYC = 40000,
   parameter int CNT_W    = $clog2(DEAD_CYC + 1)
) (
   input  logic     clk,
   input  logic     rst_n,
   input  hb_mode_e mode_tgt,
   output hb_mode_e mode_q,
   output logic     quiet
);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(DEAD_CYC);

   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("hb_dead: DEAD_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_BRK_LO;
         cnt    <= '0;
      end else if (mode_tgt != mode_q) begin
         mode_q <= mode_tgt;
         cnt    <= LOAD;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign quiet = (mode_tgt != mode_q) || (cnt != '0);

   // R7
   dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> quiet);
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
   import hb_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEAD_CYC    = 40000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_a,
   input  logic       in_b,
   input  logic       pwm_in,
   input  logic       en_a,
   input  logic       en_b,
   input  logic       cs_dis,
   input  logic       uv_flag,
   input  logic       ov_flag,
   input  logic [1:0] ot_hs,
   input  logic [1:0] oc_ls,
   output logic       hs_a_on,
   output logic       hs_b_on,
   output logic       ls_a_on,
   output logic       ls_b_on,
   output logic       diag_pd_a,
   output logic       diag_pd_b,
   output logic       sense_en,
   output logic       standby
);
   localparam int CNT_W  = $clog2(DEAD_CYC + 1);
   localparam int N_CMD  = 6;

   logic [N_CMD-1:0]    cmd_raw;
   logic [N_CMD-1:0]    cmd_s;
   logic [NUM_LEGS-1:0] dir_s;
   logic [NUM_LEGS-1:0] en_s;
   logic                pwm_s;
   logic                cs_s;
   hb_mode_e            mode_tgt;
   hb_mode_e            mode_q;
   logic                quiet;
   logic                supply_bad;
   logic [NUM_LEGS-1:0] flt;
   logic [NUM_LEGS-1:0] live;
   logic [NUM_LEGS-1:0] hs;
   logic [NUM_LEGS-1:0] ls;

   assign cmd_raw = {cs_dis, en_b, en_a, pwm_in, in_b, in_a};

   hb_sync #(.WIDTH(N_CMD), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cmd_raw),
      .q     (cmd_s)
   );

   assign dir_s    = cmd_s[1:0];
   assign pwm_s    = cmd_s[2];
   assign en_s     = cmd_s[4:3];
   assign cs_s     = cmd_s[5];
   assign mode_tgt = hb_mode_e'({dir_s[0], dir_s[1]});

   hb_dead #(.DEAD_CYC(DEAD_CYC), .CNT_W(CNT_W)) u_dead (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_tgt (mode_tgt),
      .mode_q   (mode_q),
      .quiet    (quiet)
   );

   assign supply_bad = uv_flag | ov_flag;

   generate
      for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
         hb_leg_fault u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .dir_s    (dir_s[l]),
            .fault_in (ot_hs[l] | oc_ls[l]),
            .flt_q    (flt[l])
         );
         assign live[l] = en_s[l] & ~flt[l] & ~supply_bad & ~quiet;
         assign hs[l]   = live[l] & leg_dir(mode_q, l);
         assign ls[l]   = live[l] & pwm_s & ~leg_dir(mode_q, l);
      end
   endgenerate

   assign hs_a_on   = hs[0];
   assign hs_b_on   = hs[1];
   assign ls_a_on   = ls[0];
   assign ls_b_on   = ls[1];
   assign diag_pd_a = flt[0];
   assign diag_pd_b = flt[1];
   assign sense_en  = ~cs_s & mode_drives(mode_q);
   assign standby   = ~(|dir_s) & ~pwm_s & ~(|en_s) & ~(|flt);

   // R8
   no_shoot_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_a_on || ls_a_on) |-> !(hs_a_on && ls_a_on));
   // R8
   no_shoot_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_b_on || ls_b_on) |-> !(hs_b_on && ls_b_on));
   // R8
   gap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_a_on |=> !ls_a_on);
   // R8
   gap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs_b_on |=> !ls_b_on);
   // R6
   supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uv_flag || ov_flag) |-> $countones({hs_a_on, hs_b_on, ls_a_on, ls_b_on}) == 0);
   // R2
   pwm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_s |-> (!ls_a_on && !ls_b_on));
   // R4
   diag_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ot_hs[0] || oc_ls[0]) |=> (diag_pd_a && !hs_a_on && !ls_a_on));
   // R4
   diag_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ot_hs[1] || oc_ls[1]) |=> (diag_pd_b && !hs_b_on && !ls_b_on));
endmodule

// File: tb/tb_hbridge_ctrl.sv
module tb_hbridge_ctrl;
   localparam int S = 2;
   localparam int D = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_a = 0, in_b = 0, pwm_in = 0, en_a = 0, en_b = 0, cs_dis = 0;
   logic uv_flag = 0, ov_flag = 0;
   logic [1:0] ot_hs = 2'b00, oc_ls = 2'b00;
   logic hs_a_on, hs_b_on, ls_a_on, ls_b_on, diag_pd_a, diag_pd_b, sense_en, standby;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   hbridge_ctrl #(.SYNC_STAGES(S), .DEAD_CYC(D)) dut (
      .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .pwm_in(pwm_in),
      .en_a(en_a), .en_b(en_b), .cs_dis(cs_dis), .uv_flag(uv_flag),
      .ov_flag(ov_flag), .ot_hs(ot_hs), .oc_ls(oc_ls), .hs_a_on(hs_a_on),
      .hs_b_on(hs_b_on), .ls_a_on(ls_a_on), .ls_b_on(ls_b_on),
      .diag_pd_a(diag_pd_a), .diag_pd_b(diag_pd_b), .sense_en(sense_en),
      .standby(standby)
   );

   // gates as {hs_a, hs_b, ls_a, ls_b}
   function automatic logic [3:0] gates();
      return {hs_a_on, hs_b_on, ls_a_on, ls_b_on};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic settle();
      step(S + D + 4);
   endtask

   task automatic drive(input logic a, input logic b, input logic p,
                        input logic ea, input logic eb);
      in_a = a; in_b = b; pwm_in = p; en_a = ea; en_b = eb;
   endtask

   task automatic t_reset();
      step(2);
      chk("R11 gates in reset", gates(), 4'b0000);
      chk("R11 diag in reset", {diag_pd_a, diag_pd_b}, 2'b00);
      chk("R11 standby in reset", standby, 1'b1);
      rst_n = 1'b1;
      step(3);
      chk("R11 gates after reset", gates(), 4'b0000);
      chk("R11 standby after reset", standby, 1'b1);
   endtask

   task automatic t_modes();
      drive(1, 0, 1, 1, 1); settle();
      chk("R1 mode 10", gates(), 4'b1001);
      chk("R9 sense in 10", sense_en, 1'b1);
      chk("R10 standby off when active", standby, 1'b0);
      drive(0, 1, 1, 1, 1); settle();
      chk("R1 mode 01", gates(), 4'b0110);
      chk("R9 sense in 01", sense_en, 1'b1);
      drive(1, 1, 1, 1, 1); settle();
      chk("R1 mode 11", gates(), 4'b1100);
      chk("R9 sense brake high", sense_en, 1'b0);
      drive(0, 0, 1, 1, 1); settle();
      chk("R1 mode 00", gates(), 4'b0011);
      chk("R9 sense brake low", sense_en, 1'b0);
   endtask

   task automatic t_dead();
      drive(1, 0, 1, 1, 1); settle();
      chk("R1 start 10", gates(), 4'b1001);
      drive(0, 1, 1, 1, 1);
      step(S - 1);
      chk("R12 old mode kept before sync", gates(), 4'b1001);
      step(1);
      chk("R7 first dead cycle", gates(), 4'b0000);
      step(D);
      chk("R7 last dead cycle", gates(), 4'b0000);
      step(1);
      chk("R7 new mode on", gates(), 4'b0110);
   endtask

   task automatic t_pwm();
      drive(0, 1, 0, 1, 1);
      step(S);
      chk("R2 pwm low lows off", gates(), 4'b0100);
      drive(0, 1, 1, 1, 1);
      step(S);
      chk("R2 pwm high resume", gates(), 4'b0110);
   endtask

   task automatic t_enable();
      drive(0, 1, 1, 1, 0);
      step(S);
      chk("R3 leg B disabled", gates(), 4'b0010);
      drive(0, 1, 1, 0, 1);
      step(S);
      chk("R3 leg A disabled", gates(), 4'b0100);
      drive(0, 1, 1, 1, 1);
      step(S);
      chk("R3 both enabled", gates(), 4'b0110);
   endtask

   task automatic t_supply();
      uv_flag = 1;
      step(1);
      chk("R6 undervoltage off", gates(), 4'b0000);
      uv_flag = 0;
      step(1);
      chk("R6 undervoltage release", gates(), 4'b0110);
      ov_flag = 1;
      step(1);
      chk("R6 overvoltage off", gates(), 4'b0000);
      ov_flag = 0;
      step(1);
      chk("R6 overvoltage release", gates(), 4'b0110);
      chk("R6 nothing latched", {diag_pd_a, diag_pd_b}, 2'b00);
   endtask

   task automatic t_fault_a();
      drive(1, 0, 1, 1, 1); settle();
      ot_hs = 2'b01;
      step(1);
      ot_hs = 2'b00;
      chk("R4 leg A latched diag", {diag_pd_a, diag_pd_b}, 2'b10);
      chk("R4 leg A off, B on", gates(), 4'b0001);
      step(5);
      chk("R4 latch holds", diag_pd_a, 1'b1);
      drive(1, 1, 1, 1, 1); settle();
      chk("R5 edge on B keeps A", diag_pd_a, 1'b1);
      chk("R5 leg A still off", gates(), 4'b0100);
      drive(1, 0, 1, 1, 1); settle();
      drive(0, 0, 1, 1, 1); settle();
      chk("R5 falling edge keeps A", diag_pd_a, 1'b1);
      chk("R5 brake low leg A off", gates(), 4'b0001);
      drive(1, 0, 1, 1, 1);
      step(S);
      chk("R5 before clear", diag_pd_a, 1'b1);
      step(1);
      chk("R5 cleared by rising A", diag_pd_a, 1'b0);
      settle();
      chk("R5 leg A back", gates(), 4'b1001);
   endtask

   task automatic t_fault_b();
      oc_ls = 2'b10;
      step(1);
      chk("R4 leg B latched diag", {diag_pd_a, diag_pd_b}, 2'b01);
      chk("R4 leg B off, A on", gates(), 4'b1000);
      drive(1, 1, 1, 1, 1); settle();
      chk("R5 flag held blocks clear", diag_pd_b, 1'b1);
      drive(1, 0, 1, 1, 1); settle();
      oc_ls = 2'b00;
      step(2);
      chk("R5 latched after flag drop", diag_pd_b, 1'b1);
      drive(0, 0, 0, 0, 0); settle();
      chk("R10 fault blocks standby", standby, 1'b0);
      drive(0, 1, 0, 0, 0); settle();
      drive(0, 0, 0, 0, 0); settle();
      chk("R5 cleared by rising B", diag_pd_b, 1'b0);
      chk("R10 standby after clear", standby, 1'b1);
   endtask

   task automatic t_sense();
      drive(1, 0, 1, 1, 1); settle();
      cs_dis = 1;
      step(S);
      chk("R9 cs_dis high", sense_en, 1'b0);
      cs_dis = 0;
      step(S);
      chk("R9 cs_dis low", sense_en, 1'b1);
   endtask

   task automatic t_standby();
      drive(0, 0, 0, 0, 0); settle();
      chk("R10 all low standby", standby, 1'b1);
      drive(0, 0, 1, 0, 0);
      step(S);
      chk("R10 pwm alone leaves standby", standby, 1'b0);
      drive(0, 0, 0, 0, 1);
      step(S);
      chk("R10 enable alone leaves standby", standby, 1'b0);
      drive(0, 0, 0, 0, 0);
      step(S);
      chk("R10 back to standby", standby, 1'b1);
   endtask

   initial begin
      t_reset();
      t_modes();
      t_dead();
      t_pwm();
      t_enable();
      t_supply();
      t_fault_a();
      t_fault_b();
      t_sense();
      t_standby();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule